// File: doc/BRIEF.md
# Memory Data Bus Line Tester

This engine exercises the 64 data lines between a controller and a memory word, looking for lines that are stuck, bridged together or left floating. After a start pulse it runs a fixed sequence of twelve patterns. Each pattern is stored at a chosen target word. Next, a fixed decoy word is stored at the address one above the target. Only then is the target read, and it is read a single time. Storing the decoy in between puts different charge on the bus, so a floating line cannot hand back the value that was just written.

The patterns split the 64 lines into groups of 1, 2, 4, 8, 16 and 32 adjacent lines with alternating polarity, and then repeat with each group inverted. Every pair of lines is therefore driven to opposite levels at least once, whatever the board routing. The engine compares each captured word with its pattern. When the sequence ends it reports pass or fail, the index of the first failing pattern and the word read for it. It is meant to run first in a memory self-test, before any address or cell checks.

Top module: `dbus_line_tester`

## Requirements
- R1: Pattern k (k = 0..5) has bit b equal to bit k of the binary number b. Pattern k (k = 6..11) is the bitwise inverse of pattern 11-k. Patterns are issued in index order 0 to 11, and each is written (memWe=1) to the target address, which is baseAddr sampled at start.
- R2: After each pattern write, and before that pattern's read, the word 0x0123456789ABCDEF is written to target+1. The address wraps modulo 2^ADDR_W.
- R3: Each pattern causes exactly one read request (memWe=0) to the target. The comparison uses the one word returned for it.
- R4: All twelve patterns run even after a mismatch, giving 24 writes and 12 reads per run.
- R5: failIdx and failData hold the index and read word of the first mismatching pattern. They stay unchanged until the next accepted start, which clears both to zero.
- R6: pass is 1 in the cycle done is high if and only if no mismatch occurred. It holds until the next accepted start, which clears it to 0.
- R7: done is high for exactly one cycle at the end of each run.
- R8: While memReq is high and memReady is low, memAddr, memWe and memWdata hold steady. A transfer counts only in a cycle with both memReq and memReady high.
- R9: Read data is taken only when memRdValid is high, however many cycles (at least one) it arrives after the read is accepted.
- R10: A start pulse while a run is in progress has no effect on that run, its addresses or its result.
- R11: While reset is asserted and after it is released, done, pass, memReq, failIdx and failData are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when the engine is idle |
| baseAddr | input | ADDR_W | Target word address, sampled at start |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Run result, held until the next start |
| failIdx | output | 4 | Index of the first failing pattern |
| failData | output | 64 | Word read for the first failing pattern |
| memReq | output | 1 | Memory request valid |
| memReady | input | 1 | Memory accepts the request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Word address |
| memWdata | output | 64 | Write data |
| memRdValid | input | 1 | Read data valid |
| memRdata | input | 64 | Read data |

## Verification
Faults in the pattern index or the decoy select show up on the memory port in the very next transfer, as a wrong address, data word or order. The bench records every accepted transfer and compares the whole sequence against the expected one. Faults in the failure latch or the pass flag become visible in the cycle done is high. The bench injects stuck, bridged and floating line faults into its memory model, each of which fails at a known pattern index. A wrongly held result is caught by sampling again several cycles after done and right after the next start.

// File: rtl/dbt_pkg.sv
package dbt_pkg;
  localparam int DATA_W  = 64;
  localparam int NUM_PAT = 12;
  localparam int IDX_W   = 4;
  localparam logic [DATA_W-1:0] DECOY_WORD = 64'h0123_4567_89AB_CDEF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR_PAT, ST_WR_DECOY, ST_RD_REQ, ST_RD_WAIT, ST_FINISH
  } ctrlState_t;

  typedef struct packed {
    logic clearRun;
    logic captureRd;
    logic advance;
  } dpCtrl_t;

  // Group pattern: bit b follows bit 'sel' of b; upper half inverted, mirrored order.
  function automatic logic [DATA_W-1:0] patternAt(input logic [IDX_W-1:0] idx);
    logic [DATA_W-1:0] p;
    logic [2:0] sel;
    logic [7:0] bitPos;
    logic inv;
    inv = (idx > 4'd5);
    sel = inv ? 3'(4'd11 - idx) : idx[2:0];
    for (int b = 0; b < DATA_W; b++) begin
      bitPos = 8'(b);
      p[b] = bitPos[sel];
    end
    return inv ? ~p : p;
  endfunction
endpackage

// File: rtl/dbt_ctrl.sv
module dbt_ctrl
  import dbt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    memReady,
  input  logic    memRdValid,
  input  logic    lastPat,
  output dpCtrl_t strobes,
  output logic    memReq,
  output logic    memWe,
  output logic    selDecoy,
  output logic    done
);
  ctrlState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobes   = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    selDecoy  = 1'b0;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobes.clearRun = 1'b1;
          stateNext = ST_WR_PAT;
        end
      end
      ST_WR_PAT: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memReady) stateNext = ST_WR_DECOY;
      end
      ST_WR_DECOY: begin
        memReq   = 1'b1;
        memWe    = 1'b1;
        selDecoy = 1'b1;
        if (memReady) stateNext = ST_RD_REQ;
      end
      ST_RD_REQ: begin
        memReq = 1'b1;
        if (memReady) stateNext = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (memRdValid) begin
          strobes.captureRd = 1'b1;
          if (lastPat) stateNext = ST_FINISH;
          else begin
            strobes.advance = 1'b1;
            stateNext = ST_WR_PAT;
          end
        end
      end
      ST_FINISH: begin
        done = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dbt_datapath.sv
module dbt_datapath
  import dbt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           strobes,
  input  logic              selDecoy,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [ADDR_W-1:0] baseQ,
  output logic              lastPat,
  output logic              pass,
  output logic [IDX_W-1:0]  failIdx,
  output logic [DATA_W-1:0] failData
);
  logic [IDX_W-1:0]  idxQ;
  logic              failSeen;
  logic [DATA_W-1:0] curPat;
  logic              mismatch;

  assign curPat   = patternAt(idxQ);
  assign mismatch = (memRdata != curPat);
  assign lastPat  = (idxQ == IDX_W'(NUM_PAT - 1));
  assign memAddr  = selDecoy ? baseQ + ADDR_W'(1) : baseQ;
  assign memWdata = selDecoy ? DECOY_WORD : curPat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ     <= '0;
      baseQ    <= '0;
      failSeen <= 1'b0;
      pass     <= 1'b0;
      failIdx  <= '0;
      failData <= '0;
    end else if (strobes.clearRun) begin
      idxQ     <= '0;
      baseQ    <= baseAddr;
      failSeen <= 1'b0;
      pass     <= 1'b0;
      failIdx  <= '0;
      failData <= '0;
    end else begin
      if (strobes.captureRd) begin
        if (mismatch && !failSeen) begin
          failSeen <= 1'b1;
          failIdx  <= idxQ;
          failData <= memRdata;
        end
        if (lastPat) pass <= !failSeen && !mismatch;
      end
      if (strobes.advance) idxQ <= idxQ + IDX_W'(1);
    end
  end
endmodule

// File: rtl/dbus_line_tester.sv
module dbus_line_tester
  import dbt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  output logic              done,
  output logic              pass,
  output logic [3:0]        failIdx,
  output logic [63:0]       failData,
  output logic              memReq,
  input  logic              memReady,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [63:0]       memWdata,
  input  logic              memRdValid,
  input  logic [63:0]       memRdata
);
  dpCtrl_t           strobes;
  logic              selDecoy;
  logic              lastPat;
  logic [ADDR_W-1:0] baseQ;

  dbt_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .memReady(memReady),
    .memRdValid(memRdValid), .lastPat(lastPat), .strobes(strobes),
    .memReq(memReq), .memWe(memWe), .selDecoy(selDecoy), .done(done)
  );

  dbt_datapath #(.ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .selDecoy(selDecoy),
    .baseAddr(baseAddr), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .baseQ(baseQ), .lastPat(lastPat), .pass(pass),
    .failIdx(failIdx), .failData(failData)
  );
endmodule

// File: rtl/dbt_checker.sv
module dbt_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              done,
  input logic              pass,
  input logic              memReq,
  input logic              memReady,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [63:0]       memWdata,
  input logic              memRdValid,
  input logic [ADDR_W-1:0] baseQ
);
  logic outstanding;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outstanding <= 1'b0;
    else if (memReq && memReady && !memWe) outstanding <= 1'b1;
    else if (memRdValid) outstanding <= 1'b0;
  end

  // R2
  decoy_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAddr == baseQ + ADDR_W'(1)) |-> memWdata == 64'h0123_4567_89AB_CDEF);

  // R3
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && !memWe) |-> !outstanding);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)));

  // R6
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> ($stable(pass) || done));
endmodule

bind dbus_line_tester dbt_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .done(done), .pass(pass),
  .memReq(memReq), .memReady(memReady), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memRdValid(memRdValid), .baseQ(baseQ)
);

// File: tb/dbus_line_tester_tb_top.sv
module dbus_line_tester_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int RD_LAT     = 3;
  localparam int WATCHDOG   = 20000;
  localparam logic [63:0] DECOY = 64'h0123456789ABCDEF;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic              done, pass, memReq, memWe;
  logic [3:0]        failIdx;
  logic [63:0]       failData, memWdata;
  logic [ADDR_W-1:0] memAddr;
  logic              memReady = 1'b1;
  logic              memRdValid;
  logic [63:0]       memRdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int faultMode = 0;   // 0 good, 1 bit13 low, 2 bit63 high, 3 bits0/2 AND bridge, 4 floating
  bit stallOn = 1'b0;

  logic [63:0] pats [12];
  logic [63:0] mem [256];
  logic [63:0] lastW = '0;
  logic        pv [RD_LAT];
  logic [63:0] pd [RD_LAT];
  logic [15:0] lfsr = 16'hACE1;
  logic              tWe   [512];
  logic [ADDR_W-1:0] tAddr [512];
  logic [63:0]       tData [512];
  int tCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbus_line_tester #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr), .done(done),
    .pass(pass), .failIdx(failIdx), .failData(failData), .memReq(memReq),
    .memReady(memReady), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdValid(memRdValid), .memRdata(memRdata)
  );

  function automatic logic [63:0] corrupt(input logic [63:0] v, input int mode);
    logic [63:0] r;
    logic b;
    r = v;
    case (mode)
      1: r[13] = 1'b0;
      2: r[63] = 1'b1;
      3: begin b = v[0] & v[2]; r[0] = b; r[2] = b; end
      default: r = v;
    endcase
    return r;
  endfunction

  assign memRdValid = pv[RD_LAT-1];
  assign memRdata   = pd[RD_LAT-1];

  always @(posedge clk) begin
    pv[0] <= 1'b0;
    if (memReq && memReady) begin
      tWe[tCnt % 512] = memWe;
      tAddr[tCnt % 512] = memAddr;
      tData[tCnt % 512] = memWdata;
      tCnt = tCnt + 1;
      if (memWe) begin
        mem[memAddr] <= memWdata;
        lastW <= memWdata;
      end else begin
        pv[0] <= 1'b1;
        pd[0] <= (faultMode == 4) ? lastW : corrupt(mem[memAddr], faultMode);
      end
    end
    for (int i = 1; i < RD_LAT; i++) begin
      pv[i] <= pv[i-1];
      pd[i] <= pd[i-1];
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memReady <= stallOn ? (lfsr[1:0] != 2'b00) : 1'b1;
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > WATCHDOG) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired act=%0d exp=<%0d", cycles, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic test_reset();
    chk(done == 0 && memReq == 0, "R11 done/memReq in reset", {62'd0, done, memReq}, 64'd0);
    chk(pass == 0 && failIdx == 0, "R11 pass/failIdx in reset", {59'd0, pass, failIdx}, 64'd0);
    chk(failData == 0, "R11 failData in reset", failData, 64'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(done == 0 && memReq == 0 && pass == 0, "R11 idle after reset", {61'd0, done, memReq, pass}, 64'd0);
  endtask

  // Runs one sequence under a fault model and checks every port-visible result.
  task automatic run_case(input string name, input int mode, input logic [ADDR_W-1:0] base,
                          input bit stall, input bit midStart);
    bit          expPass = 1'b1;
    logic [3:0]  expIdx = '0;
    logic [63:0] expData = '0;
    logic [63:0] rd;
    int          t0, n, reads, writes;
    bit          ok;
    logic        hPass;
    logic [3:0]  hIdx;
    logic [63:0] hData;
    for (int k = 0; k < 12; k++) begin
      rd = (mode == 4) ? DECOY : corrupt(pats[k], mode);
      if (rd != pats[k] && expPass) begin
        expPass = 1'b0;
        expIdx = 4'(k);
        expData = rd;
      end
    end
    faultMode = mode;
    stallOn = stall;
    @(negedge clk);
    baseAddr = base;
    start = 1'b1;
    t0 = tCnt;
    @(negedge clk);
    start = 1'b0;
    // R5 R6: accepted start clears the held results
    chk(pass == 0 && failIdx == 0 && failData == 0, {name, " R5 R6 cleared at start"},
        {59'd0, pass, failIdx} | failData, 64'd0);
    n = 0;
    if (midStart) begin
      repeat (6) @(negedge clk);
      baseAddr = base ^ 8'h40;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1, {name, " R7 done seen"}, {63'd0, done}, 64'd1);
    chk(pass == expPass, {name, " R6 pass at done"}, {63'd0, pass}, {63'd0, expPass});
    chk(failIdx == expIdx, {name, " R5 failIdx"}, {60'd0, failIdx}, {60'd0, expIdx});
    chk(failData == expData, {name, " R5 failData"}, failData, expData);
    // R1 R2 R3 R4: exact transfer sequence
    reads = 0; writes = 0;
    for (int i = t0; i < tCnt; i++) if (tWe[i % 512]) writes++; else reads++;
    chk(reads == 12 && writes == 24, {name, " R3 R4 transfer counts"},
        64'(reads * 100 + writes), 64'(1224));
    ok = (tCnt - t0) == 36;
    for (int k = 0; k < 12 && ok; k++) begin
      int j = t0 + 3 * k;
      if (!(tWe[j % 512] == 1 && tAddr[j % 512] == base && tData[j % 512] == pats[k])) ok = 0;
      if (!(tWe[(j+1) % 512] == 1 && tAddr[(j+1) % 512] == ADDR_W'(base + 1) && tData[(j+1) % 512] == DECOY)) ok = 0;
      if (!(tWe[(j+2) % 512] == 0 && tAddr[(j+2) % 512] == base)) ok = 0;
    end
    chk(ok, {name, " R1 R2 R10 transfer order"}, 64'(tCnt - t0), 64'd36);
    hPass = pass; hIdx = failIdx; hData = failData;
    @(negedge clk);
    chk(done == 0, {name, " R7 done single cycle"}, {63'd0, done}, 64'd0);
    stallOn = 1'b0;
    repeat (8) @(negedge clk);
    chk(pass == hPass && failIdx == hIdx && failData == hData && memReq == 0,
        {name, " R5 R6 results held"}, failData, hData);
  endtask

  initial begin
    pats[0]  = 64'hAAAAAAAAAAAAAAAA; pats[1]  = 64'hCCCCCCCCCCCCCCCC;
    pats[2]  = 64'hF0F0F0F0F0F0F0F0; pats[3]  = 64'hFF00FF00FF00FF00;
    pats[4]  = 64'hFFFF0000FFFF0000; pats[5]  = 64'hFFFFFFFF00000000;
    pats[6]  = 64'h00000000FFFFFFFF; pats[7]  = 64'h0000FFFF0000FFFF;
    pats[8]  = 64'h00FF00FF00FF00FF; pats[9]  = 64'h0F0F0F0F0F0F0F0F;
    pats[10] = 64'h3333333333333333; pats[11] = 64'h5555555555555555;
    for (int i = 0; i < RD_LAT; i++) begin pv[i] = 1'b0; pd[i] = '0; end
    #1;
    test_reset();
    run_case("good", 0, 8'h10, 1'b0, 1'b0);                // R1 R6
    run_case("stuck13", 1, 8'h20, 1'b1, 1'b0);             // R8 R9 under stalls
    run_case("high63_wrap", 2, 8'hFF, 1'b0, 1'b0);         // R2 wrap, R4 late fail
    run_case("float", 4, 8'h31, 1'b0, 1'b0);               // R2 decoy read back
    run_case("bridge", 3, 8'h05, 1'b1, 1'b0);              // R5 first fail index 1
    run_case("busy_start", 0, 8'h22, 1'b1, 1'b1);          // R10
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule